// File: doc/BRIEF.md
# Sequential Integer and Fixed-Point Divider

This block is the multi-cycle divide unit of a 32-bit RISC datapath. A request carries an unsigned 32-bit dividend, an unsigned 32-bit divisor and a format bit. With the format bit low the unit performs a plain unsigned integer division. With it high the dividend is read as a 16.16 fixed-point value: it is extended by sixteen zero fraction bits into a 48-bit numerator before the division, and the 32 least significant bits of the quotient are kept. The quotient is meant for the destination register and the remainder for a separate remainder register. Both are held in output registers that change only when a division with a nonzero divisor completes.

Requests use a valid/ready handshake. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a division is running, and a request offered during that time is neither accepted nor stored: the source must keep it or offer it again once `in_ready` returns. The result side has no back-pressure. `res_valid` is a single-cycle strobe, and the consumer must take the result in that cycle. `res_write` tells the consumer whether the register file should be written. The latency is fixed at 18 cycles whatever the operands are.

Top module: `fxdiv_unit`

## Requirements
- R1: With `fixed_mode` = 0, a completed division with divisor b ≠ 0 gives `quotient` = floor(a / b) and `remainder` = a mod b, with a and b both unsigned 32-bit.
- R2: With `fixed_mode` = 1, the numerator is the 48-bit value a·2^16. For b ≠ 0, `quotient` is bits 31..0 of floor(a·2^16 / b) and `remainder` is (a·2^16) mod b.
- R3: With divisor 0, `res_valid` still pulses at the normal time with `res_write` = 0, and `quotient` and `remainder` keep their previous values. With a nonzero divisor, `res_write` = 1 during the pulse.
- R4: If a request is accepted on rising edge E0, `res_valid` is high for exactly the cycle that follows edge E0+18 and low after edges E0+1 to E0+17.
- R5: Each accepted request produces exactly one `res_valid` cycle, and `res_valid` is low again after the next edge.
- R6: `in_ready` is low from the edge after acceptance until edge E0+18. A request offered while `in_ready` is low is ignored: it produces no result and does not change the result of the division in progress.
- R7: `in_ready` is high again in the same cycle as `res_valid`, so a request offered in that cycle is accepted on the next edge, back to back.
- R8: After reset, `in_ready` = 1, `res_valid` = 0, `res_write` = 0, `quotient` = 0 and `remainder` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit is idle and can accept a request |
| dividend | input | 32 | Unsigned dividend (16.16 value when fixed_mode = 1) |
| divisor | input | 32 | Unsigned divisor |
| fixed_mode | input | 1 | 0 = integer division, 1 = 16.16 fixed-point division |
| res_valid | output | 1 | One-cycle strobe: division finished |
| res_write | output | 1 | With res_valid: results were updated (divisor nonzero) |
| quotient | output | 32 | Quotient register, low 32 bits |
| remainder | output | 32 | Remainder register |

## Verification
Each result is due exactly 18 rising edges after the edge that accepted its request. The bench therefore counts edges from acceptance. After each of the first 17 edges it samples at the falling edge that `res_valid` is low and `in_ready` is low. After the 18th edge it checks the strobe, the write flag and both result registers against a 64-bit arithmetic model. The next request is driven in that same falling-edge window, so every operation also exercises the back-to-back acceptance and the one-cycle strobe. During the busy cycles the bench offers other requests, and the results must still match the operands that were accepted.

// File: rtl/fxdiv_pkg.sv
`timescale 1ns/1ps
package fxdiv_pkg;
  // Shape of one radix step: digit width and the number of candidate multiples.
  function automatic int multiples_of(input int digit_w);
    return (1 << digit_w) - 1;
  endfunction

  // Number of digit steps needed to consume a numerator of num_w bits.
  function automatic int steps_for(input int num_w, input int digit_w);
    return (num_w + digit_w - 1) / digit_w;
  endfunction
endpackage

// File: rtl/fxdiv_digit.sv
`timescale 1ns/1ps
// One restoring step of high radix: shifts DIGIT_W numerator bits into the
// partial remainder and picks the largest multiple of the divisor that fits.
module fxdiv_digit #(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 3
) (
  input  logic [DATA_W-1:0]  part_in,
  input  logic [DIGIT_W-1:0] bits_in,
  input  logic [DATA_W-1:0]  divisor,
  output logic [DATA_W-1:0]  part_out,
  output logic [DIGIT_W-1:0] digit
);
  localparam int EXT_W = DATA_W + DIGIT_W;
  localparam int NMUL  = fxdiv_pkg::multiples_of(DIGIT_W);

  logic [EXT_W-1:0] wide;
  logic [EXT_W-1:0] mult [0:NMUL];
  logic [NMUL:1]    fits;

  assign wide    = {part_in, bits_in};
  assign mult[0] = '0;

  // Candidate multiples 1..NMUL of the divisor, compared in parallel.
  for (genvar k = 1; k <= NMUL; k++) begin : g_mult
    assign mult[k] = EXT_W'(divisor) * EXT_W'(k);
    assign fits[k] = (wide >= mult[k]);
  end

  // Multiples are increasing, so the last one that fits is the digit.
  always_comb begin
    digit = '0;
    for (int k = 1; k <= NMUL; k++) begin
      if (fits[k]) digit = DIGIT_W'(k);
    end
  end

  assign part_out = DATA_W'(wide - mult[digit]);
endmodule

// File: rtl/fxdiv_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accepts a request when idle, runs ITERS digit steps, and
// finishes on the LATENCY-th edge after acceptance.
module fxdiv_ctrl #(
  parameter int LATENCY = 18,
  parameter int ITERS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic step,
  output logic finish
);
  localparam int CNT_W = $clog2(LATENCY);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;
  assign step     = busy && (cnt < CNT_W'(ITERS));
  assign finish   = busy && (cnt == CNT_W'(LATENCY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // An accepted request makes the unit busy on the next cycle.
  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // Finishing frees the unit for a new request in the next cycle.
  assert_finish_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> in_ready);
endmodule

// File: rtl/fxdiv_unit.sv
`timescale 1ns/1ps
// Sequential unsigned divider: integer or 16.16 fixed-point, fixed latency.
module fxdiv_unit #(
  parameter int DATA_W  = 32,
  parameter int FRAC_W  = 16,
  parameter int DIGIT_W = 3,
  parameter int LATENCY = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  input  logic              fixed_mode,
  output logic              res_valid,
  output logic              res_write,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder
);
  localparam int NUM_W = DATA_W + FRAC_W;
  localparam int ITERS = fxdiv_pkg::steps_for(NUM_W, DIGIT_W);
  localparam int PAD_W = ITERS * DIGIT_W;
  localparam int LAT_W = $clog2(LATENCY + 1);

  logic               accept, step, finish;
  logic [PAD_W-1:0]   num_q;
  logic [DATA_W-1:0]  part_q, div_q, quo_acc;
  logic [DATA_W-1:0]  part_next;
  logic [DIGIT_W-1:0] digit;

  fxdiv_ctrl #(.LATENCY(LATENCY), .ITERS(ITERS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .step     (step),
    .finish   (finish)
  );

  fxdiv_digit #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_digit (
    .part_in  (part_q),
    .bits_in  (num_q[PAD_W-1 -: DIGIT_W]),
    .divisor  (div_q),
    .part_out (part_next),
    .digit    (digit)
  );

  // Operand capture and the digit iteration.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q   <= '0;
      part_q  <= '0;
      div_q   <= '0;
      quo_acc <= '0;
    end else if (accept) begin
      num_q   <= fixed_mode ? PAD_W'({dividend, FRAC_W'(0)}) : PAD_W'(dividend);
      part_q  <= '0;
      div_q   <= divisor;
      quo_acc <= '0;
    end else if (step) begin
      num_q   <= num_q << DIGIT_W;
      part_q  <= part_next;
      quo_acc <= {quo_acc[DATA_W-DIGIT_W-1:0], digit};
    end
  end

  // Result registers: written only for a nonzero divisor.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_write <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      res_valid <= finish;
      res_write <= finish && (div_q != '0);
      if (finish && (div_q != '0)) begin
        quotient  <= quo_acc;
        remainder <= part_q;
      end
    end
  end

  // Edge counter from acceptance, used only by the latency property.
  logic [LAT_W-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            lat_cnt <= LAT_W'(LATENCY);
    else if (accept)                       lat_cnt <= '0;
    else if (lat_cnt != LAT_W'(LATENCY))   lat_cnt <= lat_cnt + LAT_W'(1);
  end

  assert_part_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) |-> (part_q < div_q));

  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_write |-> (remainder < div_q));

  assert_zero_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_write) |-> ($stable(quotient) && $stable(remainder)));

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(lat_cnt) == LAT_W'(LATENCY - 1)));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(div_q));
endmodule

// File: tb/fxdiv_unit_test.sv
`timescale 1ns/1ps
module fxdiv_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] dividend = '0, divisor = '0;
  logic        fixed_mode = 1'b0;
  logic        res_valid, res_write;
  logic [31:0] quotient, remainder;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] last_q = '0, last_r = '0;

  always #10 clk = ~clk;

  fxdiv_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .fixed_mode(fixed_mode),
    .res_valid(res_valid), .res_write(res_write),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_q(input logic [31:0] a, input logic [31:0] b, input logic m);
    logic [63:0] n = m ? ({32'b0, a} << 16) : {32'b0, a};
    return {32'b0, 32'(n / {32'b0, b})};
  endfunction

  function automatic logic [63:0] model_r(input logic [31:0] a, input logic [31:0] b, input logic m);
    logic [63:0] n = m ? ({32'b0, a} << 16) : {32'b0, a};
    return n % {32'b0, b};
  endfunction

  // Called at a falling edge with the unit idle; returns at the falling edge
  // after the result edge, leaving the unit idle again.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic m, input bit noise);
    logic [31:0] eq, er;
    chk("R7 in_ready idle before request", {63'b0, in_ready}, 64'd1);
    in_valid = 1'b1; dividend = a; divisor = b; fixed_mode = m;
    @(posedge clk); @(negedge clk);
    chk("R5 strobe low after acceptance edge", {63'b0, res_valid}, 64'd0);
    for (int i = 1; i <= 17; i++) begin
      if (noise) begin
        in_valid = 1'b1; dividend = $urandom; divisor = $urandom; fixed_mode = ~m;
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk); @(negedge clk);
      chk("R4 no result before edge 18", {63'b0, res_valid}, 64'd0);
      chk("R6 in_ready low while busy", {63'b0, in_ready}, 64'd0);
    end
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R4 result strobe at edge 18", {63'b0, res_valid}, 64'd1);
    chk("R7 in_ready with result", {63'b0, in_ready}, 64'd1);
    if (b == 32'd0) begin
      chk("R3 write flag low for zero divisor", {63'b0, res_write}, 64'd0);
      chk("R3 quotient kept", {32'b0, quotient}, {32'b0, last_q});
      chk("R3 remainder kept", {32'b0, remainder}, {32'b0, last_r});
    end else begin
      eq = 32'(model_q(a, b, m));
      er = 32'(model_r(a, b, m));
      chk("R3 write flag high", {63'b0, res_write}, 64'd1);
      chk(m ? "R2 fixed quotient" : "R1 integer quotient", {32'b0, quotient}, {32'b0, eq});
      chk(m ? "R2 fixed remainder" : "R1 integer remainder", {32'b0, remainder}, {32'b0, er});
      last_q = eq;
      last_r = er;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; vectors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    chk("R8 reset in_ready", {63'b0, in_ready}, 64'd1);
    chk("R8 reset res_valid", {63'b0, res_valid}, 64'd0);
    chk("R8 reset res_write", {63'b0, res_write}, 64'd0);
    chk("R8 reset quotient", {32'b0, quotient}, 64'd0);
    chk("R8 reset remainder", {32'b0, remainder}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners.
    run_op(32'd100, 32'd7, 1'b0, 1'b0);                 // R1: 14 r 2
    run_op(32'd5, 32'd0, 1'b0, 1'b1);                   // R3 hold
    run_op(32'd1, 32'd3, 1'b1, 1'b0);                   // R2: 21845 r 1
    run_op(32'hFFFF_FFFF, 32'd1, 1'b1, 1'b1);           // R2 truncation
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);   // R1: 1 r 0
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);   // R2: 0x10000
    run_op(32'd3, 32'd10, 1'b0, 1'b1);                  // R1 quotient 0
    run_op(32'h1234_5678, 32'd0, 1'b1, 1'b0);           // R3 hold, fixed mode
    run_op(32'd7, 32'h8000_0000, 1'b1, 1'b0);           // R2 small numerator
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk("R5 no strobe while idle", {63'b0, res_valid}, 64'd0);
    end

    // Random mix.
    for (int n = 0; n < 250; n++) begin
      logic [31:0] a, b;
      logic [2:0]  sel;
      a   = $urandom;
      sel = 3'($urandom % 8);
      b   = (sel == 0) ? 32'd0 : (sel < 3) ? ($urandom % 32) : $urandom;
      if (sel == 7) a = $urandom % 1000;
      run_op(a, b, 1'($urandom % 2), bit'($urandom % 2));
      if ($urandom % 5 == 0) begin
        @(posedge clk); @(negedge clk);
        chk("R5 strobe drops when idle", {63'b0, res_valid}, 64'd0);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule